// File: doc/BRIEF.md
# Class-Partitioned Network Input Buffer with Request Refusal

This block sits on the receive side of a node's network interface. Every arriving transaction carries a class bit, and the block sorts it into one of two first-in first-out pools: one for requests that other nodes send to this node, and one for replies to requests that this node issued. Each pool has its own reserved space. The reply pool never waits behind request traffic, so the network input keeps taking replies even while requests pile up or while the node cannot send anything.

The request pool holds K*(P-1) entries, where K bounds the outstanding requests a node may have and P is the node count. The reply pool holds K entries, which covers every reply that this node's own requests can bring back. When a request arrives and the request pool is full, the block does not stall the input. It drops the request and pulses a refusal output with the sender's id, and the sender has to retry. The node drains each pool through its own valid/pop port.

Top module: `ni_rx_class_buffer`

## Requirements
- R1: Requests (class bit 0) are stored in arrival order and delivered in that order on the request port. The request pool holds exactly K*(P-1) entries, which is 14 with the defaults K=2 and P=8.
- R2: Replies (class bit 1) are stored in arrival order and delivered in that order on the reply port. The reply pool holds exactly K entries, which is 2 by default.
- R3: When a valid request arrives while the request pool's full flag is set, the request is not stored. In the next cycle `nack_valid` is high for one cycle, and `nack_src` equals the refused packet's source id.
- R4: `in_ready` is high whenever `in_cls` is 0, whatever the state of either pool.
- R5: When `in_cls` is 1, `in_ready` equals "reply pool not full", independent of the request pool. A reply presented while `in_ready` is high is stored even when the request pool is full.
- R6: The full and empty flags are registered, and admission uses their value at the start of the cycle. A pop in the same cycle as an arrival to a full pool does not admit that arrival: a request is refused as in R3, and a reply sees `in_ready` low and is not stored.
- R7: A synchronous active-high reset empties both pools and clears any pending refusal. After reset, `req_valid`, `rep_valid` and `nack_valid` are low.
- R8: `nack_valid` is low in every cycle that does not follow a refused request, including every cycle that follows an accepted request or reply.
- R9: A pop on an empty pool has no effect. The pool stays empty, and a packet pushed in that same cycle becomes the next head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Arriving packet present |
| in_cls | input | 1 | Packet class: 0 request, 1 reply |
| in_src | input | SRC_W | Source node id of the arriving packet |
| in_data | input | DATA_W | Payload of the arriving packet |
| in_ready | output | 1 | Arrival can be taken this cycle |
| req_valid | output | 1 | Request pool not empty |
| req_src | output | SRC_W | Source id at the head of the request pool |
| req_data | output | DATA_W | Payload at the head of the request pool |
| req_pop | input | 1 | Remove the head of the request pool |
| rep_valid | output | 1 | Reply pool not empty |
| rep_src | output | SRC_W | Source id at the head of the reply pool |
| rep_data | output | DATA_W | Payload at the head of the reply pool |
| rep_pop | input | 1 | Remove the head of the reply pool |
| nack_valid | output | 1 | Refusal pulse toward the network |
| nack_src | output | SRC_W | Source id of the refused request |

## Verification
Two events can land in the same cycle and interact. The first is a pop that frees a slot in a full pool while a new arrival targets that pool. The second is a request being refused while a reply is being accepted. The bench fills the request pool and then offers requests in cycles where it also pops the request port, and it mixes replies into the same cycles. A behavioural queue model rules on each case from the occupancy at the start of the cycle. Every clock the bench compares the head contents, the valid flags, `in_ready` and the refusal pulse against that model.

// File: rtl/ni_rx_pkg.sv
package ni_rx_pkg;
  typedef enum logic {
    CLS_REQ = 1'b0,
    CLS_REP = 1'b1
  } pkt_class_e;
endpackage

// File: rtl/ni_rx_fifo.sv
// Synchronous FIFO with registered full/empty flags; storage array has no
// reset so it can map onto RAM resources.
module ni_rx_fifo #(
  parameter int DEPTH = 14,
  parameter int WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt, cnt_nx;
  logic             full_q, empty_q;
  logic             do_push, do_pop;

  // Admission uses the flags registered at the start of the cycle.
  assign do_push = push_i & ~full_q;
  assign do_pop  = pop_i & ~empty_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_comb begin
    cnt_nx = cnt;
    case ({do_push, do_pop})
      2'b10:   cnt_nx = cnt + 1'b1;
      2'b01:   cnt_nx = cnt - 1'b1;
      default: cnt_nx = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      cnt     <= cnt_nx;
      full_q  <= (cnt_nx == CAP);
      empty_q <= (cnt_nx == '0);
    end
  end

  assign rdata_o = mem[rd_ptr];
  assign empty_o = empty_q;
  assign full_o  = full_q;

  // R1/R2: a full pool stays full until something is popped.
  a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (full_q && !pop_i) |=> full_q);
  // R9: popping an empty pool with no push leaves it empty.
  a_r9_empty_pop: assert property (@(posedge clk) disable iff (rst)
    (empty_q && pop_i && !push_i) |=> empty_q);
  // R9: flags are never both set.
  a_r9_flags_excl: assert property (@(posedge clk) disable iff (rst)
    !(full_q && empty_q));
endmodule

// File: rtl/ni_rx_admit.sv
// Class steering and admission decision for one arriving packet.
module ni_rx_admit
  import ni_rx_pkg::*;
(
  input  logic in_valid_i,
  input  logic in_cls_i,
  input  logic req_full_i,
  input  logic rep_full_i,
  output logic in_ready_o,
  output logic req_push_o,
  output logic rep_push_o,
  output logic refuse_o
);
  pkt_class_e cls;
  assign cls = pkt_class_e'(in_cls_i);

  always_comb begin
    in_ready_o = 1'b1;
    req_push_o = 1'b0;
    rep_push_o = 1'b0;
    refuse_o   = 1'b0;
    if (cls == CLS_REP) begin
      in_ready_o = ~rep_full_i;
      rep_push_o = in_valid_i & ~rep_full_i;
    end else begin
      req_push_o = in_valid_i & ~req_full_i;
      refuse_o   = in_valid_i & req_full_i;
    end
  end
endmodule

// File: rtl/ni_rx_nack.sv
// One-cycle refusal pulse carrying the sender id.
module ni_rx_nack #(
  parameter int SRC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refuse_i,
  input  logic [SRC_W-1:0] src_i,
  output logic             nack_valid_o,
  output logic [SRC_W-1:0] nack_src_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      nack_valid_o <= 1'b0;
      nack_src_o   <= '0;
    end else begin
      nack_valid_o <= refuse_i;
      if (refuse_i) nack_src_o <= src_i;
    end
  end

  a_r3_nack_follows: assert property (@(posedge clk) disable iff (rst)
    refuse_i |=> (nack_valid_o && nack_src_o == $past(src_i)));
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !refuse_i |=> !nack_valid_o);
endmodule

// File: rtl/ni_rx_class_buffer.sv
module ni_rx_class_buffer #(
  parameter int K      = 2,
  parameter int P      = 8,
  parameter int DATA_W = 16,
  parameter int SRC_W  = (P > 1) ? $clog2(P) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_cls,
  input  logic [SRC_W-1:0]  in_src,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              req_valid,
  output logic [SRC_W-1:0]  req_src,
  output logic [DATA_W-1:0] req_data,
  input  logic              req_pop,
  output logic              rep_valid,
  output logic [SRC_W-1:0]  rep_src,
  output logic [DATA_W-1:0] rep_data,
  input  logic              rep_pop,
  output logic              nack_valid,
  output logic [SRC_W-1:0]  nack_src
);
  localparam int REQ_DEPTH = K * (P - 1);
  localparam int REP_DEPTH = K;
  localparam int WORD_W    = SRC_W + DATA_W;

  logic req_full, req_empty, rep_full, rep_empty;
  logic req_push, rep_push, refuse;
  logic [WORD_W-1:0] word_in, req_word, rep_word;

  assign word_in = {in_src, in_data};

  ni_rx_admit u_admit (
    .in_valid_i (in_valid),
    .in_cls_i   (in_cls),
    .req_full_i (req_full),
    .rep_full_i (rep_full),
    .in_ready_o (in_ready),
    .req_push_o (req_push),
    .rep_push_o (rep_push),
    .refuse_o   (refuse)
  );

  ni_rx_fifo #(.DEPTH(REQ_DEPTH), .WIDTH(WORD_W)) u_req_pool (
    .clk     (clk),
    .rst     (rst),
    .push_i  (req_push),
    .wdata_i (word_in),
    .pop_i   (req_pop),
    .rdata_o (req_word),
    .empty_o (req_empty),
    .full_o  (req_full)
  );

  ni_rx_fifo #(.DEPTH(REP_DEPTH), .WIDTH(WORD_W)) u_rep_pool (
    .clk     (clk),
    .rst     (rst),
    .push_i  (rep_push),
    .wdata_i (word_in),
    .pop_i   (rep_pop),
    .rdata_o (rep_word),
    .empty_o (rep_empty),
    .full_o  (rep_full)
  );

  ni_rx_nack #(.SRC_W(SRC_W)) u_nack (
    .clk          (clk),
    .rst          (rst),
    .refuse_i     (refuse),
    .src_i        (in_src),
    .nack_valid_o (nack_valid),
    .nack_src_o   (nack_src)
  );

  assign req_valid = ~req_empty;
  assign rep_valid = ~rep_empty;
  assign {req_src, req_data} = req_word;
  assign {rep_src, rep_data} = rep_word;

  // R5: an accepted reply is visible on the reply port next cycle.
  a_r5_reply_taken: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls && in_ready) |=> rep_valid);
  // R3/R6: a refused request leaves a non-popped full pool full.
  a_r6_refused_not_stored: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_cls && req_full && !req_pop) |=> req_full);
  // R7: nothing is visible in the cycle after reset.
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!req_valid && !rep_valid && !nack_valid));
endmodule

// File: tb/sim_ni_rx_class_buffer.sv
`timescale 1ns/1ps
module sim_ni_rx_class_buffer;
  localparam int K = 2, P = 8, DW = 16, SW = 3;
  localparam int RQD = K * (P - 1);
  localparam int RPD = K;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, in_valid = 1'b0, in_cls = 1'b0, req_pop = 1'b0, rep_pop = 1'b0;
  logic [SW-1:0] in_src = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, req_valid, rep_valid, nack_valid;
  logic [SW-1:0] req_src, rep_src, nack_src;
  logic [DW-1:0] req_data, rep_data;

  ni_rx_class_buffer #(.K(K), .P(P), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_src(in_src),
    .in_data(in_data), .in_ready(in_ready), .req_valid(req_valid), .req_src(req_src),
    .req_data(req_data), .req_pop(req_pop), .rep_valid(rep_valid), .rep_src(rep_src),
    .rep_data(rep_data), .rep_pop(rep_pop), .nack_valid(nack_valid), .nack_src(nack_src)
  );

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  logic [SW+DW-1:0] mreq[$], mrep[$];
  logic exp_nack;
  logic [SW-1:0] exp_nsrc;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_outputs();
    chk(req_valid == (mreq.size() > 0), "R1 req_valid", req_valid, mreq.size() > 0);
    if (mreq.size() > 0)
      chk({req_src, req_data} == mreq[0], "R1 request order", {req_src, req_data}, mreq[0]);
    chk(rep_valid == (mrep.size() > 0), "R2 rep_valid", rep_valid, mrep.size() > 0);
    if (mrep.size() > 0)
      chk({rep_src, rep_data} == mrep[0], "R2 reply order", {rep_src, rep_data}, mrep[0]);
    chk(nack_valid == exp_nack, exp_nack ? "R3 nack pulse" : "R8 nack idle", nack_valid, exp_nack);
    if (exp_nack) chk(nack_src == exp_nsrc, "R3 nack source", nack_src, exp_nsrc);
  endtask

  // One clock: drive at negedge, predict from start-of-cycle occupancy, compare after edge.
  task automatic cycle(input logic v, input logic c, input logic [SW-1:0] s,
                       input logic [DW-1:0] d, input logic qp, input logic pp);
    bit rq_full, rp_full;
    @(negedge clk);
    in_valid = v; in_cls = c; in_src = s; in_data = d; req_pop = qp; rep_pop = pp;
    #1;
    rq_full = (mreq.size() == RQD);
    rp_full = (mrep.size() == RPD);
    if (c) chk(in_ready == !rp_full, "R5 reply ready", in_ready, !rp_full);
    else   chk(in_ready == 1'b1, "R4 request ready", in_ready, 1);
    exp_nack = 1'b0;
    if (qp && mreq.size() > 0) void'(mreq.pop_front());
    if (pp && mrep.size() > 0) void'(mrep.pop_front());
    if (v && !c) begin
      if (!rq_full) mreq.push_back({s, d});
      else begin exp_nack = 1'b1; exp_nsrc = s; end
    end
    if (v && c && !rp_full) mrep.push_back({s, d});
    @(posedge clk); #1;
    compare_outputs();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_cls = 1'b0; req_pop = 1'b0; rep_pop = 1'b0;
    @(posedge clk); #1;
    mreq.delete(); mrep.delete(); exp_nack = 1'b0;
    chk(!req_valid && !rep_valid && !nack_valid, "R7 reset clears",
        {req_valid, rep_valid, nack_valid}, 0);
    @(negedge clk); rst = 1'b0; in_valid = 1'b0;
  endtask

  initial begin
    exp_nack = 1'b0;
    repeat (3) @(posedge clk);
    do_reset();
    // R9: pop on empty with simultaneous push
    cycle(1'b1, 1'b0, 3'd5, 16'h1111, 1'b1, 1'b1);
    cycle(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b0);
    chk(!req_valid, "R9 empty after drain", req_valid, 0);
    cycle(1'b0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1);
    // R1: fill request pool, then overflow for R3 with replies mixed (R5)
    for (int i = 0; i < RQD; i++) cycle(1'b1, 1'b0, 3'(i), 16'(16'h100 + i), 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 3'd6, 16'hdead, 1'b0, 1'b0);
    cycle(1'b1, 1'b1, 3'd2, 16'hbeef, 1'b0, 1'b0);
    cycle(1'b1, 1'b0, 3'd1, 16'hdea1, 1'b0, 1'b0);
    cycle(1'b1, 1'b1, 3'd3, 16'hbee2, 1'b0, 1'b0);
    // R5/R6: reply pool full, pop and third reply same cycle -> not taken
    cycle(1'b1, 1'b1, 3'd4, 16'hbee3, 1'b0, 1'b1);
    // R6: request pop and request arrival while full -> refused
    cycle(1'b1, 1'b0, 3'd7, 16'hcafe, 1'b1, 1'b0);
    cycle(1'b1, 1'b0, 3'd2, 16'hcaf2, 1'b0, 1'b0);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int ph = (i / 500) % 4;
      logic pq, pr;
      pq = ($urandom % 4) < ((ph == 0) ? 1 : (ph == 1) ? 3 : 2);
      pr = ($urandom % 4) < ((ph == 2) ? 1 : 3);
      cycle(($urandom % 4) != 0, $urandom % 2, 3'($urandom), 16'($urandom), pq, pr);
      if (i == 2100) do_reset();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!finished) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule